// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block gathers every reset request of a small system-on-chip and turns them into two domain resets: a system-wide reset and a reset confined to the CPU core. The requests come from an active-low external reset pin, a one-cycle timeout pulse from the watchdog, a software write that must carry a key value, and a wakeup event tagged with the low-power mode being left. Leaving sleep restarts the whole system. Leaving deep-stop restarts only the CPU core, and the rest of the logic keeps its state. The real-time-clock domain has no output here and is never reset.

The external pin is synchronised with two flops that clear asynchronously. Each domain has its own hold counter that keeps the reset low for a parameterised number of cycles after the last request. The output is then released through a two-flop synchroniser, and it asserts as soon as the hold counter or the pin demands it. A reset-out pin indication follows the system reset. A latched cause register records the source of the most recent reset, and only the external pin clears it. The battery-fault input is synchronised and held inactive while the hardware reset is in progress.

Top module: `rstctl_top`

## Requirements
- R1: With ext_rst_n low, sys_rst_n, cpu_rst_n and rst_out_n are low without waiting for a clock edge, and reset_cause reads 0 (hardware). This holds from any prior state.
- R2: After ext_rst_n rises, all three reset outputs remain low through the (HOLD+3)-th following rising edge and are high after the (HOLD+4)-th.
- R3: A wdog_trip sampled high at a rising edge drives sys_rst_n and cpu_rst_n low right after that edge and sets reset_cause to 1.
- R4: A write with sw_wr_en high and sw_wr_data equal to SW_KEY resets both domains and sets reset_cause to 2. Any other data value, or the key value without sw_wr_en, causes no reset and leaves reset_cause unchanged.
- R5: wake_req high with wake_deep low (leaving sleep) resets both domains and sets reset_cause to 3.
- R6: wake_req high with wake_deep high (leaving deep-stop) drives only cpu_rst_n low. sys_rst_n stays high and reset_cause becomes 4.
- R7: A domain reset stays low through the (HOLD+1)-th rising edge after the edge that sampled its last request, and is high after the (HOLD+2)-th. A new request restarts the hold.
- R8: rst_out_n equals sys_rst_n at all times.
- R9: reset_cause is kept through resets that do not come from the pin. When requests coincide, the priority is watchdog, then software, then sleep wakeup, then deep-stop wakeup.
- R10: batt_fault_o is 0 while the hardware reset is in progress, whatever batt_fault_in does. After release it follows batt_fault_in through two flops.
- R11: cpu_rst_n is low whenever sys_rst_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdog_trip | input | 1 | Watchdog timeout pulse, synchronous |
| sw_wr_en | input | 1 | Software reset register write strobe |
| sw_wr_data | input | KEY_W | Software reset register write data |
| wake_req | input | 1 | Wakeup event from a low-power mode |
| wake_deep | input | 1 | Mode being left: 0 sleep, 1 deep-stop |
| batt_fault_in | input | 1 | Battery-fault input, asynchronous |
| sys_rst_n | output | 1 | System-domain reset, active low |
| cpu_rst_n | output | 1 | CPU-core reset, active low |
| rst_out_n | output | 1 | Reset-out pin indication, active low |
| batt_fault_o | output | 1 | Synchronised battery fault, masked during hardware reset |
| reset_cause | output | 3 | Latched cause: 0 hw, 1 watchdog, 2 software, 3 sleep wake, 4 deep-stop wake |

## Verification
The bench builds the block with HOLD set to 4, keeping the default key width and key value. With this short hold every release edge can be counted exactly, so the checks can sample the one cycle before release and the release cycle itself for each source. The same setting also lets a second request land inside a running hold, which shows whether the hold restarts. The stimulus table covers coinciding requests, which exercises the cause priority, and the bench also pulls the pin low between clock edges.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;
  localparam int CAUSE_W = 3;

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_HW    = 3'd0,
    CAUSE_WDOG  = 3'd1,
    CAUSE_SW    = 3'd2,
    CAUSE_SLEEP = 3'd3,
    CAUSE_DEEP  = 3'd4
  } cause_e;

  localparam int NDOM    = 2;
  localparam int DOM_SYS = 0;
  localparam int DOM_CPU = 1;
endpackage

// File: rtl/rstctl_sync.sv
module rstctl_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_nxt;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sr_nxt = d;
    end else begin : g_many
      always_comb sr_nxt = {sr_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= {STAGES{RST_VAL}};
    else        sr_q <= sr_nxt;
  end

  assign q = sr_q[STAGES-1];
endmodule

// File: rtl/rstctl_stretch.sv
module rstctl_stretch #(
  parameter int HOLD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic active
);
  localparam int CNT_W = (HOLD < 2) ? 1 : $clog2(HOLD + 1);
  localparam logic [CNT_W-1:0] HOLD_V = CNT_W'(HOLD);
  localparam logic [CNT_W-1:0] ONE_V  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             act_q, act_nxt;

  always_comb begin
    cnt_nxt = cnt_q;
    act_nxt = act_q;
    if (req) begin
      cnt_nxt = HOLD_V;
      act_nxt = 1'b1;
    end else if (cnt_q != '0) begin
      cnt_nxt = cnt_q - ONE_V;
      act_nxt = (cnt_q != ONE_V);
    end else begin
      act_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= HOLD_V;
      act_q <= 1'b1;
    end else begin
      cnt_q <= cnt_nxt;
      act_q <= act_nxt;
    end
  end

  assign active = act_q;
endmodule

// File: rtl/rstctl_cause.sv
module rstctl_cause
  import rstctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hit_wdog,
  input  logic               hit_sw,
  input  logic               hit_sleep,
  input  logic               hit_deep,
  output logic [CAUSE_W-1:0] cause
);
  cause_e cause_q, cause_nxt;
  logic   upd_en;

  assign upd_en = hit_wdog | hit_sw | hit_sleep | hit_deep;

  always_comb begin
    cause_nxt = cause_q;
    if (hit_wdog)       cause_nxt = CAUSE_WDOG;
    else if (hit_sw)    cause_nxt = CAUSE_SW;
    else if (hit_sleep) cause_nxt = CAUSE_SLEEP;
    else if (hit_deep)  cause_nxt = CAUSE_DEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cause_q <= CAUSE_HW;
    else if (upd_en) cause_q <= cause_nxt;
  end

  assign cause = cause_q;
endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
  import rstctl_pkg::*;
#(
  parameter int              HOLD        = 16,
  parameter int              SYNC_STAGES = 2,
  parameter int              KEY_W       = 16,
  parameter logic [KEY_W-1:0] SW_KEY     = KEY_W'(16'h5A3C)
) (
  input  logic               clk,
  input  logic               ext_rst_n,
  input  logic               wdog_trip,
  input  logic               sw_wr_en,
  input  logic [KEY_W-1:0]   sw_wr_data,
  input  logic               wake_req,
  input  logic               wake_deep,
  input  logic               batt_fault_in,
  output logic               sys_rst_n,
  output logic               cpu_rst_n,
  output logic               rst_out_n,
  output logic               batt_fault_o,
  output logic [CAUSE_W-1:0] reset_cause
);
  logic            por_n;
  logic            hit_sw, hit_sleep, hit_deep, sys_req;
  logic [NDOM-1:0] dom_req, dom_act, dom_rel_n, dom_out_n;

  rstctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_por_sync (
    .clk(clk), .rst_n(ext_rst_n), .d(1'b1), .q(por_n)
  );

  assign hit_sw    = sw_wr_en && (sw_wr_data == SW_KEY);
  assign hit_sleep = wake_req && !wake_deep;
  assign hit_deep  = wake_req && wake_deep;
  assign sys_req   = wdog_trip | hit_sw | hit_sleep;

  assign dom_req[DOM_SYS] = sys_req;
  assign dom_req[DOM_CPU] = sys_req | hit_deep;

  generate
    for (genvar g = 0; g < NDOM; g++) begin : g_dom
      rstctl_stretch #(.HOLD(HOLD)) u_hold (
        .clk(clk), .rst_n(por_n), .req(dom_req[g]), .active(dom_act[g])
      );
      assign dom_rel_n[g] = por_n & ~dom_act[g];
      rstctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rel (
        .clk(clk), .rst_n(dom_rel_n[g]), .d(1'b1), .q(dom_out_n[g])
      );
    end
  endgenerate

  rstctl_cause u_cause (
    .clk(clk), .rst_n(por_n),
    .hit_wdog(wdog_trip), .hit_sw(hit_sw),
    .hit_sleep(hit_sleep), .hit_deep(hit_deep),
    .cause(reset_cause)
  );

  rstctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_batt_sync (
    .clk(clk), .rst_n(por_n), .d(batt_fault_in), .q(batt_fault_o)
  );

  assign sys_rst_n = dom_out_n[DOM_SYS];
  assign cpu_rst_n = dom_out_n[DOM_CPU];
  assign rst_out_n = dom_out_n[DOM_SYS];
endmodule

// File: rtl/rstctl_chk.sv
module rstctl_chk (
  input logic       clk,
  input logic       ext_rst_n,
  input logic       wdog_trip,
  input logic       sw_wr_en,
  input logic       wake_req,
  input logic       wake_deep,
  input logic       sys_rst_n,
  input logic       cpu_rst_n,
  input logic       rst_out_n,
  input logic       batt_fault_o,
  input logic [2:0] reset_cause
);
  // R1
  pin_forces_reset_chk: assert property (@(posedge clk)
    !ext_rst_n |-> (!sys_rst_n && !cpu_rst_n && reset_cause == 3'd0));

  // R3
  wdog_asserts_sys_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
    wdog_trip |=> (!sys_rst_n && !cpu_rst_n));

  // R6
  deep_wake_cpu_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (wake_req && wake_deep) |=> !cpu_rst_n);

  // R8
  rst_out_follows_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
    rst_out_n == sys_rst_n);

  // R9
  cause_holds_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
    !(wdog_trip || sw_wr_en || wake_req) |=> $stable(reset_cause));

  // R10
  batt_masked_chk: assert property (@(posedge clk)
    !ext_rst_n |-> !batt_fault_o);

  // R11
  cpu_covers_sys_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
    !sys_rst_n |-> !cpu_rst_n);
endmodule

bind rstctl_top rstctl_chk u_rstctl_chk (
  .clk(clk), .ext_rst_n(ext_rst_n), .wdog_trip(wdog_trip),
  .sw_wr_en(sw_wr_en), .wake_req(wake_req), .wake_deep(wake_deep),
  .sys_rst_n(sys_rst_n), .cpu_rst_n(cpu_rst_n), .rst_out_n(rst_out_n),
  .batt_fault_o(batt_fault_o), .reset_cause(reset_cause)
);

// File: tb/rstctl_top_tb_top.sv
`timescale 1ns/1ps
module rstctl_top_tb_top;
  localparam int HOLD = 4;
  localparam logic [15:0] KEY = 16'h5A3C;

  typedef struct packed {
    logic        wd;
    logic        sw;
    logic [15:0] data;
    logic        wk;
    logic        dp;
    logic        e_sys;
    logic        e_cpu;
    logic [2:0]  e_cause;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b1, 1'b1, 3'd1}, // R3
    '{1'b0, 1'b1, 16'h1234, 1'b0, 1'b0, 1'b0, 1'b0, 3'd1}, // R4 bad key
    '{1'b0, 1'b1, 16'h5A3C, 1'b0, 1'b0, 1'b1, 1'b1, 3'd2}, // R4 key
    '{1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, 1'b1, 1'b1, 3'd3}, // R5
    '{1'b0, 1'b0, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b1, 3'd4}, // R6
    '{1'b1, 1'b1, 16'h5A3C, 1'b0, 1'b0, 1'b1, 1'b1, 3'd1}, // R9
    '{1'b0, 1'b1, 16'h5A3C, 1'b1, 1'b1, 1'b1, 1'b1, 3'd2}, // R9
    '{1'b0, 1'b0, 16'h5A3C, 1'b0, 1'b0, 1'b0, 1'b0, 3'd2}  // R4 no strobe
  };

  logic        clk = 1'b0;
  logic        ext_rst_n;
  logic        wdog_trip, sw_wr_en, wake_req, wake_deep, batt_fault_in;
  logic [15:0] sw_wr_data;
  logic        sys_rst_n, cpu_rst_n, rst_out_n, batt_fault_o;
  logic [2:0]  reset_cause;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  rstctl_top #(.HOLD(HOLD), .KEY_W(16), .SW_KEY(KEY)) dut_i (
    .clk(clk), .ext_rst_n(ext_rst_n), .wdog_trip(wdog_trip),
    .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data), .wake_req(wake_req),
    .wake_deep(wake_deep), .batt_fault_in(batt_fault_in),
    .sys_rst_n(sys_rst_n), .cpu_rst_n(cpu_rst_n), .rst_out_n(rst_out_n),
    .batt_fault_o(batt_fault_o), .reset_cause(reset_cause)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic wd, input logic sw, input logic [15:0] data,
                       input logic wk, input logic dp);
    @(negedge clk);
    wdog_trip = wd; sw_wr_en = sw; sw_wr_data = data; wake_req = wk; wake_deep = dp;
    @(negedge clk);
    wdog_trip = 1'b0; sw_wr_en = 1'b0; sw_wr_data = '0; wake_req = 1'b0; wake_deep = 1'b0;
  endtask

  // called at the negedge right after the sampling edge
  task automatic wait_release(input logic sys_low, input logic cpu_low);
    repeat (HOLD + 1) @(negedge clk);
    check("R7 sys held", 32'(sys_rst_n), 32'(!sys_low));
    check("R7 cpu held", 32'(cpu_rst_n), 32'(!cpu_low));
    @(negedge clk);
    check("R7 sys released", 32'(sys_rst_n), 32'd1);
    check("R7 cpu released", 32'(cpu_rst_n), 32'd1);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    ext_rst_n = 1'b0; wdog_trip = 1'b0; sw_wr_en = 1'b0; sw_wr_data = '0;
    wake_req = 1'b0; wake_deep = 1'b0; batt_fault_in = 1'b1;
    repeat (3) @(negedge clk);
    // R1 R10 reset state
    check("R1 sys low", 32'(sys_rst_n), 32'd0);
    check("R1 cpu low", 32'(cpu_rst_n), 32'd0);
    check("R8 out low", 32'(rst_out_n), 32'd0);
    check("R1 cause hw", 32'(reset_cause), 32'd0);
    check("R10 batt masked", 32'(batt_fault_o), 32'd0);
    ext_rst_n = 1'b1;
    repeat (HOLD + 3) @(negedge clk);
    check("R2 sys still low", 32'(sys_rst_n), 32'd0);
    check("R2 cpu still low", 32'(cpu_rst_n), 32'd0);
    @(negedge clk);
    check("R2 sys released", 32'(sys_rst_n), 32'd1);
    check("R2 cpu released", 32'(cpu_rst_n), 32'd1);
    check("R8 out released", 32'(rst_out_n), 32'd1);
    check("R10 batt passes", 32'(batt_fault_o), 32'd1);
    batt_fault_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 batt follows", 32'(batt_fault_o), 32'd0);

    for (int i = 0; i < NV; i++) begin
      pulse(VECS[i].wd, VECS[i].sw, VECS[i].data, VECS[i].wk, VECS[i].dp);
      check($sformatf("R3-6 vec%0d sys", i), 32'(sys_rst_n), 32'(!VECS[i].e_sys));
      check($sformatf("R11 vec%0d cpu", i), 32'(cpu_rst_n), 32'(!VECS[i].e_cpu));
      check($sformatf("R8 vec%0d out", i), 32'(rst_out_n), 32'(sys_rst_n));
      check($sformatf("R9 vec%0d cause", i), 32'(reset_cause), 32'(VECS[i].e_cause));
      if (VECS[i].e_cpu) wait_release(VECS[i].e_sys, VECS[i].e_cpu);
      else repeat (2) @(negedge clk);
    end

    // R7 restart: second watchdog pulse inside the hold
    pulse(1'b1, 1'b0, '0, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    pulse(1'b1, 1'b0, '0, 1'b0, 1'b0);
    check("R7 low after second", 32'(sys_rst_n), 32'd0);
    wait_release(1'b1, 1'b1);

    // R6 deep-stop wake during no other activity keeps sys up
    pulse(1'b0, 1'b0, '0, 1'b1, 1'b1);
    check("R6 sys stays", 32'(sys_rst_n), 32'd1);
    check("R6 cpu low", 32'(cpu_rst_n), 32'd0);
    wait_release(1'b0, 1'b1);

    // R1 pin dropped between edges, cause cleared from nonzero
    check("R1 cause before", 32'(reset_cause), 32'd4);
    batt_fault_in = 1'b1;
    @(negedge clk);
    #1 ext_rst_n = 1'b0;
    #0.5;
    check("R1 async sys", 32'(sys_rst_n), 32'd0);
    check("R1 async cpu", 32'(cpu_rst_n), 32'd0);
    check("R1 cause cleared", 32'(reset_cause), 32'd0);
    check("R10 batt masked again", 32'(batt_fault_o), 32'd0);
    repeat (2) @(negedge clk);
    ext_rst_n = 1'b1;
    repeat (HOLD + 3) @(negedge clk);
    check("R2 second release low", 32'(sys_rst_n), 32'd0);
    @(negedge clk);
    check("R2 second release high", 32'(sys_rst_n), 32'd1);
    finish_run();
  end
endmodule